// File: doc/BRIEF.md
# Pseudo-SRAM Nonvolatile Memory Access Sequencer

This block sits between a synchronous host and an external 128K x 8 nonvolatile memory that offers an asynchronous pseudo-SRAM pin interface. The host presents one read or write at a time through a request/ready handshake. The block then produces the whole pin sequence. It drives the address first. It opens the access with a chip-enable edge that latches the address on the memory. It holds the enable for a bounded active window with write-enable or output-enable inside it. It closes the access and keeps the memory deselected for a precharge gap before the next access may start.

Every analog timing figure is given in nanoseconds as a parameter. The block converts each one to a whole number of clock cycles, rounding up so that every minimum is met. The active window is also checked against its maximum. Read data comes back on a one-cycle completion pulse. Writes report through the same pulse. The data bus is split into an output, an input and a drive-enable for an external tristate buffer. The block drives the bus only for writes. After reset it keeps the memory deselected for a power-up hold time before it accepts any request.

Top module: `nvm_psram_seq`

## Requirements
- R1: While rst_ni is low, and asynchronously when it falls, mem_ce_n_o and mem_we_n_o and mem_oe_n_o are 1 and mem_dq_oe_o, ready_o and done_o are 0. After reset releases, the memory stays deselected and ready_o stays 0 for the power-up hold. With the default parameters, ready_o is first seen high after the 11th rising edge.
- R2: The 17-bit address of an accepted request appears on mem_addr_o at least the setup count of cycles before mem_ce_n_o falls (2 cycles by default). It does not change while mem_ce_n_o is low.
- R3: Each access holds mem_ce_n_o low for exactly the active count (27 cycles by default). This count never reaches the maximum of T_CA_MAX_NS worth of cycles. mem_ce_o is always the inverse of mem_ce_n_o.
- R4: Between two accesses mem_ce_n_o stays high for at least the precharge count (7 cycles by default). Falling edge to falling edge takes at least the cycle minimum (32 cycles by default).
- R5: A write (we_i = 1) drives mem_we_n_o low on exactly the cycles mem_ce_n_o is low, and keeps mem_oe_n_o high. It asserts mem_dq_oe_o with the write byte on mem_dq_o from the setup phase until the precharge ends, so the data stays driven when mem_we_n_o rises.
- R6: A read (we_i = 0) drives mem_oe_n_o low on exactly the cycles mem_ce_n_o is low, and keeps mem_we_n_o high. mem_dq_oe_o is never 1 while mem_oe_n_o is 0. mem_dq_i is captured on the last active cycle and returned on rdata_o.
- R7: done_o is a single-cycle pulse in the first cycle after mem_ce_n_o rises, once per access. For a read, rdata_o holds the captured byte from that cycle on.
- R8: A request is taken only on a clock edge where req_i and ready_o are both 1. ready_o drops in the next cycle and stays low until the precharge ends. Changes on req_i, we_i, addr_i and wdata_i during an access have no effect on that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Host request valid |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 17 | Host word address |
| wdata_i | input | 8 | Host write byte |
| ready_o | output | 1 | Idle, request may be taken |
| done_o | output | 1 | Access completion pulse |
| rdata_o | output | 8 | Read byte |
| mem_ce_n_o | output | 1 | Memory chip enable, active low |
| mem_ce_o | output | 1 | Memory chip enable, active high |
| mem_we_n_o | output | 1 | Memory write enable, active low |
| mem_oe_n_o | output | 1 | Memory output enable, active low |
| mem_addr_o | output | 17 | Memory address |
| mem_dq_o | output | 8 | Data toward the memory |
| mem_dq_oe_o | output | 1 | Drive enable for the external data tristate |
| mem_dq_i | input | 8 | Data from the memory |

## Verification
The bench reads every window length off the pins and compares it with counts rounded up from the nanosecond figures. A conversion that rounds down, or that forgets the access time or the cycle minimum, shows up as a short active window, a short precharge gap or a short falling-edge-to-falling-edge period. The bench changes the request inputs during each access. A design that reads them live puts a wrong address on the pins, writes the wrong byte or mixes up the direction. The bench also checks that the bus is released before OE goes low, that WE lines up with the enable, and that the data is still driven when the write ends. It checks the hold after reset and aborts an access with reset to see the pins close at once.

// File: rtl/nvm_seq_pkg.sv
package nvm_seq_pkg;

  typedef enum logic [2:0] {
    ST_PWRUP,
    ST_IDLE,
    ST_SETUP,
    ST_ACTIVE,
    ST_PRECH
  } seq_state_e;

  function automatic int ns_to_cyc(input int ns, input int period_ns);
    return (ns + period_ns - 1) / period_ns;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/nvm_seq_fsm.sv
module nvm_seq_fsm
  import nvm_seq_pkg::*;
#(
  parameter int AS_C   = 2,
  parameter int ACT_C  = 27,
  parameter int PRE_C  = 7,
  parameter int PU_C   = 11,
  parameter int CNT_W  = 5
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_i,
  output seq_state_e state_q_o,
  output seq_state_e state_d_o,
  output logic       last_act_o
);

  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_zero;

  assign cnt_zero = (cnt_q == '0);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_zero ? cnt_q : cnt_q - 1'b1;
    unique case (state_q)
      ST_PWRUP:  if (cnt_zero) state_d = ST_IDLE;
      ST_IDLE:   if (req_i) begin
                   state_d = ST_SETUP;
                   cnt_d   = CNT_W'(AS_C - 1);
                 end
      ST_SETUP:  if (cnt_zero) begin
                   state_d = ST_ACTIVE;
                   cnt_d   = CNT_W'(ACT_C - 1);
                 end
      ST_ACTIVE: if (cnt_zero) begin
                   state_d = ST_PRECH;
                   cnt_d   = CNT_W'(PRE_C - 1);
                 end
      ST_PRECH:  if (cnt_zero) state_d = ST_IDLE;
      default:   state_d = ST_PWRUP;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_PWRUP;
      cnt_q   <= CNT_W'(PU_C - 1);
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign state_q_o  = state_q;
  assign state_d_o  = state_d;
  assign last_act_o = (state_q == ST_ACTIVE) && cnt_zero;

  // a new access starts only from idle with a request
  p_take_from_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SETUP && $past(state_q) != ST_SETUP) |->
      $past(state_q == ST_IDLE && req_i));

  p_idle_after_prech_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(state_q) == ST_PRECH && state_q != ST_PRECH) |-> state_q == ST_IDLE);

endmodule

// File: rtl/nvm_seq_pins.sv
module nvm_seq_pins
  import nvm_seq_pkg::*;
#(
  parameter int AW      = 17,
  parameter int DW      = 8,
  parameter int ACT_C   = 27,
  parameter int CAMAX_C = 250
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          accept_i,
  input  logic          req_we_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  input  seq_state_e    state_d_i,
  output logic          wr_o,
  output logic          ce_n_o,
  output logic          ce_o,
  output logic          we_n_o,
  output logic          oe_n_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] dq_o,
  output logic          dq_oe_o
);

  localparam int LCW = $clog2(CAMAX_C + 1);

  logic          wr_q, wr_n;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic          act_d, busy_d;
  logic [LCW-1:0] low_cnt_q;

  assign wr_n   = accept_i ? req_we_i : wr_q;
  assign act_d  = (state_d_i == ST_ACTIVE);
  assign busy_d = (state_d_i == ST_SETUP) || act_d || (state_d_i == ST_PRECH);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept_i) begin
      wr_q    <= req_we_i;
      addr_q  <= req_addr_i;
      wdata_q <= req_wdata_i;
    end
  end

  // pins come straight from flops, decoded from the next state
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ce_n_o  <= 1'b1;
      ce_o    <= 1'b0;
      we_n_o  <= 1'b1;
      oe_n_o  <= 1'b1;
      dq_oe_o <= 1'b0;
    end else begin
      ce_n_o  <= !act_d;
      ce_o    <= act_d;
      we_n_o  <= !(act_d && wr_n);
      oe_n_o  <= !(act_d && !wr_n);
      dq_oe_o <= busy_d && wr_n;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) low_cnt_q <= '0;
    else if (ce_n_o) low_cnt_q <= '0;
    else if (low_cnt_q != LCW'(CAMAX_C)) low_cnt_q <= low_cnt_q + 1'b1;
  end

  assign wr_o   = wr_q;
  assign addr_o = addr_q;
  assign dq_o   = wdata_q;

  p_ce_below_max_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ce_n_o |-> low_cnt_q < LCW'(CAMAX_C));

  p_ce_len_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ce_n_o) |-> $past(low_cnt_q) == LCW'(ACT_C - 1));

  p_ce_pair_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_o != ce_n_o);

  p_addr_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_n_o && $past(!ce_n_o)) |-> $stable(addr_o));

  p_we_inside_ce_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_n_o |-> (!ce_n_o && dq_oe_o));

  p_bus_released_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_n_o |-> !dq_oe_o);

endmodule

// File: rtl/nvm_seq_rdcap.sv
module nvm_seq_rdcap #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          last_act_i,
  input  logic          wr_i,
  input  logic [DW-1:0] dq_i,
  output logic [DW-1:0] rdata_o,
  output logic          done_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o <= '0;
      done_o  <= 1'b0;
    end else begin
      done_o <= last_act_i;
      if (last_act_i && !wr_i) rdata_o <= dq_i;
    end
  end

  p_done_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_rdata_stable_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(last_act_i) |-> $stable(rdata_o));

endmodule

// File: rtl/nvm_psram_seq.sv
module nvm_psram_seq
  import nvm_seq_pkg::*;
#(
  parameter int CLK_NS      = 8,
  parameter int AW          = 17,
  parameter int DW          = 8,
  parameter int T_AS_NS     = 10,
  parameter int T_AH_NS     = 50,
  parameter int T_CA_NS     = 210,
  parameter int T_CA_MAX_NS = 2000,
  parameter int T_WP_NS     = 210,
  parameter int T_ACC_NS    = 100,
  parameter int T_PC_NS     = 40,
  parameter int T_DH_NS     = 50,
  parameter int T_OHZ_NS    = 25,
  parameter int T_CYC_NS    = 250,
  parameter int T_PU_NS     = 85
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          ready_o,
  output logic          done_o,
  output logic [DW-1:0] rdata_o,
  output logic          mem_ce_n_o,
  output logic          mem_ce_o,
  output logic          mem_we_n_o,
  output logic          mem_oe_n_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_dq_o,
  output logic          mem_dq_oe_o,
  input  logic [DW-1:0] mem_dq_i
);

  localparam int AS_C    = imax(1, ns_to_cyc(T_AS_NS, CLK_NS));
  // active window covers enable minimum, write pulse, access time plus a capture cycle, address hold
  localparam int ACT_C   = imax(imax(ns_to_cyc(T_CA_NS, CLK_NS), ns_to_cyc(T_WP_NS, CLK_NS)),
                                imax(ns_to_cyc(T_ACC_NS, CLK_NS) + 1, ns_to_cyc(T_AH_NS, CLK_NS)));
  localparam int CYC_C   = ns_to_cyc(T_CYC_NS, CLK_NS);
  // precharge also absorbs data hold, output float and whatever the cycle minimum still needs
  localparam int PRE_C   = imax(imax(imax(1, ns_to_cyc(T_PC_NS, CLK_NS)), ns_to_cyc(T_DH_NS, CLK_NS)),
                                imax(ns_to_cyc(T_OHZ_NS, CLK_NS), CYC_C - AS_C - ACT_C));
  localparam int PU_C    = imax(1, ns_to_cyc(T_PU_NS, CLK_NS));
  localparam int CAMAX_C = T_CA_MAX_NS / CLK_NS;
  localparam int CNT_W   = $clog2(imax(imax(AS_C, ACT_C), imax(PRE_C, PU_C)) + 1);

  seq_state_e state_q, state_d;
  logic       last_act, accept, wr;

  assign ready_o = (state_q == ST_IDLE);
  assign accept  = ready_o && req_i;

  nvm_seq_fsm #(
    .AS_C (AS_C),
    .ACT_C(ACT_C),
    .PRE_C(PRE_C),
    .PU_C (PU_C),
    .CNT_W(CNT_W)
  ) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (req_i),
    .state_q_o (state_q),
    .state_d_o (state_d),
    .last_act_o(last_act)
  );

  nvm_seq_pins #(
    .AW     (AW),
    .DW     (DW),
    .ACT_C  (ACT_C),
    .CAMAX_C(CAMAX_C)
  ) u_pins (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .accept_i   (accept),
    .req_we_i   (we_i),
    .req_addr_i (addr_i),
    .req_wdata_i(wdata_i),
    .state_d_i  (state_d),
    .wr_o       (wr),
    .ce_n_o     (mem_ce_n_o),
    .ce_o       (mem_ce_o),
    .we_n_o     (mem_we_n_o),
    .oe_n_o     (mem_oe_n_o),
    .addr_o     (mem_addr_o),
    .dq_o       (mem_dq_o),
    .dq_oe_o    (mem_dq_oe_o)
  );

  nvm_seq_rdcap #(
    .DW(DW)
  ) u_rdcap (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .last_act_i(last_act),
    .wr_i      (wr),
    .dq_i      (mem_dq_i),
    .rdata_o   (rdata_o),
    .done_o    (done_o)
  );

  p_ready_drops_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> !ready_o);

endmodule

// File: tb/nvm_psram_seq_tb.sv
module nvm_psram_seq_tb;

  localparam int P = 8;
  localparam int B_AS  = (10 + P - 1) / P;
  localparam int B_CA  = (210 + P - 1) / P;
  localparam int B_ACC = (100 + P - 1) / P + 1;
  localparam int B_ACT = (B_CA > B_ACC) ? B_CA : B_ACC;
  localparam int B_CYC = (250 + P - 1) / P;
  localparam int B_DH  = (50 + P - 1) / P;
  localparam int B_PRE = (B_DH > B_CYC - B_AS - B_ACT) ? B_DH : B_CYC - B_AS - B_ACT;
  localparam int B_PU  = (85 + P - 1) / P;

  localparam int NV = 10;
  // {write, address, write byte, expected read byte}
  localparam logic [33:0] VECS [NV] = '{
    {1'b1, 17'h00012, 8'hA5, 8'h00},
    {1'b1, 17'h1FFFF, 8'h3C, 8'h00},
    {1'b0, 17'h00012, 8'h00, 8'hA5},
    {1'b0, 17'h1FFFF, 8'h00, 8'h3C},
    {1'b1, 17'h10034, 8'h77, 8'h00},
    {1'b0, 17'h10034, 8'h00, 8'h77},
    {1'b0, 17'h00056, 8'h00, 8'h0C},
    {1'b1, 17'h00012, 8'h0F, 8'h00},
    {1'b0, 17'h00012, 8'h00, 8'h0F},
    {1'b0, 17'h00000, 8'h00, 8'h5A}
  };

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [16:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        ready, done, ce_n, ce, we_n, oe_n, dq_oe;
  logic [7:0]  rdata, dq_o, dq_i;
  logic [16:0] maddr;

  always #4 clk = ~clk;

  nvm_psram_seq u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .ready_o(ready), .done_o(done), .rdata_o(rdata),
    .mem_ce_n_o(ce_n), .mem_ce_o(ce), .mem_we_n_o(we_n), .mem_oe_n_o(oe_n),
    .mem_addr_o(maddr), .mem_dq_o(dq_o), .mem_dq_oe_o(dq_oe), .mem_dq_i(dq_i)
  );

  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // memory model
  logic [7:0]  mem [256];
  logic [16:0] lat = '0;
  assign dq_i = (!ce_n && !oe_n) ? mem[lat[7:0]] : 8'hEE;

  // pin monitor
  bit          mon_en = 1'b1, seen_rise = 1'b0, exp_wr = 1'b0;
  logic [16:0] exp_addr = '0, prev_addr = '0;
  logic        prev_ce = 1'b1, prev_we = 1'b1;
  int low_len = 0, we_len = 0, oe_len = 0, hi_len = 0, f2f = 0, setup_len = 0, falls = 0;
  bit conflict = 1'b0, addr_moved = 1'b0, ce2_bad = 1'b0, hold_bad = 1'b0;

  always @(negedge clk) begin
    if (!rst_ni) begin
      seen_rise = 1'b0;
      prev_ce = 1'b1;
      prev_we = 1'b1;
    end else begin
      if (ce != !ce_n) ce2_bad = 1'b1;
      if (prev_ce && !ce_n) begin
        if (mon_en) begin
          check(setup_len >= B_AS, "R2 address setup cycles", setup_len, B_AS);
          check(maddr == exp_addr, "R2 address at enable fall", maddr, exp_addr);
          if (seen_rise) begin
            check(hi_len >= B_PRE, "R4 precharge gap", hi_len, B_PRE);
            check(f2f >= B_CYC, "R4 cycle period", f2f, B_CYC);
          end
        end
        falls++;
        lat = maddr;
        low_len = 0; we_len = 0; oe_len = 0; f2f = 0;
        conflict = 1'b0; addr_moved = 1'b0; hold_bad = 1'b0;
      end
      if (!prev_ce && ce_n) begin
        if (mon_en) begin
          check(low_len == B_ACT, "R3 enable active cycles", low_len, B_ACT);
          check(!ce2_bad, "R3 high enable is inverse", ce2_bad, 0);
          check(!addr_moved, "R2 address held while enabled", addr_moved, 0);
          if (exp_wr) begin
            check(we_len == B_ACT && oe_len == 0, "R5 write strobes", we_len, B_ACT);
            check(!conflict && !hold_bad, "R5 write data driven", conflict, 0);
          end else begin
            check(oe_len == B_ACT && we_len == 0, "R6 read strobes", oe_len, B_ACT);
            check(!conflict, "R6 bus released during read", conflict, 0);
          end
        end
        seen_rise = 1'b1;
        hi_len = 0;
      end
      if (prev_we == 1'b0 && we_n && mon_en) begin
        if (!dq_oe) hold_bad = 1'b1;
        mem[lat[7:0]] = dq_o;
      end
      f2f++;
      if (!ce_n) begin
        low_len++;
        if (!we_n) we_len++;
        if (!oe_n) oe_len++;
        if (!we_n && !dq_oe) conflict = 1'b1;
        if (maddr != lat) addr_moved = 1'b1;
      end else begin
        hi_len++;
        if (!we_n || !oe_n) conflict = 1'b1;
        setup_len = (maddr == prev_addr) ? setup_len + 1 : 1;
      end
      if (!oe_n && dq_oe) conflict = 1'b1;
      prev_addr = maddr;
      prev_ce = ce_n;
      prev_we = we_n;
    end
  end

  task automatic do_access(input bit w, input logic [16:0] a, input logic [7:0] d,
                           output logic [7:0] got);
    bit ce_low_seen;
    @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = d;
    exp_wr = w; exp_addr = a;
    while (!ready) @(negedge clk);
    @(negedge clk);
    check(!ready, "R8 ready drops after accept", ready, 0);
    // scramble inputs mid-access, keep req high
    addr = ~a; wdata = ~d; we = ~w;
    ce_low_seen = 1'b0;
    while (!done) begin
      if (!ce_n) ce_low_seen = 1'b1;
      @(negedge clk);
    end
    check(ce_n && ce_low_seen, "R7 done after enable rises", ce_n, 1);
    check(!ready, "R8 busy during precharge", ready, 0);
    got = rdata;
    req = 1'b0;
    @(negedge clk);
    check(!done, "R7 done single cycle", done, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      check(1'b0, "watchdog expired", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] got;
    int k;
    bit pu_ok;
    for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h5A;

    repeat (3) @(negedge clk);
    check(ce_n && we_n && oe_n && !dq_oe, "R1 pins idle in reset", {ce_n, we_n, oe_n, dq_oe}, 4'b1110);
    check(!ready && !done, "R1 ready and done low in reset", {ready, done}, 0);

    rst_ni = 1'b1;
    k = 0; pu_ok = 1'b1;
    do begin
      @(negedge clk);
      k++;
      if (!ce_n) pu_ok = 1'b0;
    end while (!ready && k < 100);
    check(k == B_PU, "R1 power-up hold length", k, B_PU);
    check(pu_ok, "R1 deselected during power-up", pu_ok, 1);

    // table walk
    for (int v = 0; v < NV; v++) begin
      do_access(VECS[v][33], VECS[v][32:16], VECS[v][15:8], got);
      if (!VECS[v][33])
        check(got == VECS[v][7:0], $sformatf("R6 read data vector %0d", v), got, VECS[v][7:0]);
    end
    check(falls == NV, "R8 one access per request", falls, NV);

    // reset abort during a write
    mon_en = 1'b0;
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = 17'h00077; wdata = 8'h99;
    exp_wr = 1'b1; exp_addr = 17'h00077;
    while (ce_n) @(negedge clk);
    req = 1'b0;
    repeat (5) @(negedge clk);
    rst_ni = 1'b0;
    #1;
    check(ce_n && we_n && !dq_oe && !ready, "R1 async reset closes access", {ce_n, we_n, dq_oe, ready}, 4'b1100);
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    k = 0;
    do begin
      @(negedge clk);
      k++;
    end while (!ready && k < 100);
    check(k == B_PU, "R1 power-up hold after abort", k, B_PU);
    mon_en = 1'b1;

    do_access(1'b0, 17'h00012, 8'h00, got);
    check(got == 8'h0F, "R6 read after abort", got, 8'h0F);
    do_access(1'b1, 17'h000AB, 8'hC3, got);
    do_access(1'b0, 17'h000AB, 8'h00, got);
    check(got == 8'hC3, "R5 write then read back", got, 8'hC3);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule